// File: doc/BRIEF.md
# Next-PC Prediction and Selection

This block is the program-counter stage of a five-stage in-order pipeline. In every cycle it chooses the address that fetch should use. It also forms a guess of the next address from the instruction that was just fetched. The guess is static. Sequential instructions go to the incremented address. Unconditional jumps and calls go to their embedded target. Conditional jumps are always assumed taken.

A wrong guess is repaired late. When a conditional jump reaches the memory stage with a false condition, the fall-through address carried by that stage redirects fetch. The block also raises a flag so that the two younger instructions fetched on the wrong path can be squashed. Return instructions get no real guess. The stall logic outside this block holds fetch until the return reaches write-back, and the block then takes the return address read in that stage.

The guessed address is kept in a register. That register is cleared to zero by reset and frozen while the fetch stall input is high.

Top module: `next_pc_unit`

## Requirements
- R1: When `fetch_stall` is low and `f_kind` is 0 (sequential instruction), `pred_pc` equals the value of `f_incr_pc` from that edge, starting one cycle later.
- R2: When `fetch_stall` is low and `f_kind` is 1 (call or unconditional jump), `pred_pc` takes the value of `f_const_tgt` one cycle later.
- R3: When `fetch_stall` is low and `f_kind` is 2 (conditional jump), `pred_pc` takes the value of `f_const_tgt` one cycle later, because the jump is assumed taken.
- R4: When `fetch_stall` is low and `f_kind` is 3 (return), `pred_pc` takes the value of `f_incr_pc` one cycle later. This value is only a placeholder: the external stall keeps it from being used.
- R5: When `m_is_cjump` is high and `m_cond_true` is low, `fetch_pc` equals `m_fallthru` and `mispredict` is high, in the same cycle.
- R6: When there is no mispredict and `w_is_ret` is high, `fetch_pc` equals `w_ret_addr` in the same cycle.
- R7: When a mispredict and a write-back return occur in the same cycle, `fetch_pc` equals `m_fallthru`.
- R8: When there is neither a mispredict nor a write-back return, `fetch_pc` equals `pred_pc`.
- R9: `mispredict` is low whenever `m_is_cjump` is low or `m_cond_true` is high.
- R10: Reset is synchronous and active low. A clock edge with `rst_n` low sets `pred_pc` to 0, and this overrides `fetch_stall`.
- R11: While `fetch_stall` is high and `rst_n` is high, `pred_pc` keeps its value across the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_stall | input | 1 | Freezes the predicted-PC register |
| f_kind | input | 2 | Class of the fetched instruction: 0 sequential, 1 call or jump, 2 conditional jump, 3 return |
| f_incr_pc | input | ADDR_W | Address that follows the fetched instruction |
| f_const_tgt | input | ADDR_W | Embedded target of the fetched instruction |
| m_is_cjump | input | 1 | The memory stage holds a conditional jump |
| m_cond_true | input | 1 | Condition outcome of that jump |
| m_fallthru | input | ADDR_W | Fall-through address carried by the memory stage |
| w_is_ret | input | 1 | The write-back stage holds a return |
| w_ret_addr | input | ADDR_W | Return address read from memory, held in write-back |
| fetch_pc | output | ADDR_W | Address used for fetch in this cycle |
| pred_pc | output | ADDR_W | Stored predicted next address |
| mispredict | output | 1 | Request to squash the two wrong-path instructions |

## Verification
Two redirects can fall in the same cycle: a not-taken conditional jump in the memory stage and a return in write-back. The bench produces this case as part of a full sweep over every combination of instruction class, memory-stage jump and outcome, write-back return and stall. In that cycle it expects the fall-through address on `fetch_pc` and `mispredict` high. In the same sweep it checks that the predicted-PC register takes its update or holds it according to the stall, whatever redirect is active.

// File: rtl/npc_pkg.sv
// Package: shared types for the next-PC unit.
// Assumes the instruction class arrives already decoded as a 2-bit code.
package npc_pkg;

    typedef enum logic [1:0] {
        KIND_SEQ   = 2'd0,
        KIND_JUMP  = 2'd1,
        KIND_CJUMP = 2'd2,
        KIND_RET   = 2'd3
    } insn_kind_e;

endpackage

// File: rtl/npc_predict.sv
// Module: npc_predict
// Forms the static next-address guess from the instruction that was just
// fetched. Assumes the class code is valid in every cycle. A return
// yields the incremented address, which serves only as a placeholder
// because fetch is held outside this block until the real target is known.
module npc_predict
    import npc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  insn_kind_e          kind,
    input  logic [ADDR_W-1:0]   incr_pc,
    input  logic [ADDR_W-1:0]   const_tgt,
    output logic [ADDR_W-1:0]   guess
);

    // Choose between the embedded target and the incremented address.
    always_comb begin
        unique case (kind)
            KIND_JUMP, KIND_CJUMP: guess = const_tgt;
            default:               guess = incr_pc;
        endcase
    end

endmodule

// File: rtl/npc_hold_reg.sv
// Module: npc_hold_reg
// Register that holds the predicted next address. Synchronous active-low
// reset to zero, which wins over the stall. Holds its value while stalled.
module npc_hold_reg #(
    parameter int ADDR_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hold,
    input  logic [ADDR_W-1:0]   d,
    output logic [ADDR_W-1:0]   q
);

    // Reset, hold or load the stored guess.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (!hold)
            q <= d;
    end

    // R11
    hold_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(q));

endmodule

// File: rtl/npc_select.sv
// Module: npc_select
// Chooses the fetch address. The memory-stage correction comes first, then
// the write-back return address, then the stored guess. Also raises the
// squash request when a conditional jump is found not taken.
module npc_select #(
    parameter int ADDR_W = 32
) (
    input  logic                m_is_cjump,
    input  logic                m_cond_true,
    input  logic [ADDR_W-1:0]   m_fallthru,
    input  logic                w_is_ret,
    input  logic [ADDR_W-1:0]   w_ret_addr,
    input  logic [ADDR_W-1:0]   stored_guess,
    output logic [ADDR_W-1:0]   fetch_pc,
    output logic                mispredict
);

    // Detect a conditional jump whose assumed-taken guess was wrong.
    always_comb mispredict = m_is_cjump && !m_cond_true;

    // Apply the fixed redirect priority.
    always_comb begin
        if (mispredict)
            fetch_pc = m_fallthru;
        else if (w_is_ret)
            fetch_pc = w_ret_addr;
        else
            fetch_pc = stored_guess;
    end

endmodule

// File: rtl/next_pc_unit.sv
// Module: next_pc_unit
// PC stage of a five-stage in-order pipeline: predicts the next address and
// selects the fetch address, redirecting on a late branch correction or a
// return target. Stall and bubble decisions are made outside this block.
module next_pc_unit
    import npc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fetch_stall,
    input  logic [1:0]          f_kind,
    input  logic [ADDR_W-1:0]   f_incr_pc,
    input  logic [ADDR_W-1:0]   f_const_tgt,
    input  logic                m_is_cjump,
    input  logic                m_cond_true,
    input  logic [ADDR_W-1:0]   m_fallthru,
    input  logic                w_is_ret,
    input  logic [ADDR_W-1:0]   w_ret_addr,
    output logic [ADDR_W-1:0]   fetch_pc,
    output logic [ADDR_W-1:0]   pred_pc,
    output logic                mispredict
);

    insn_kind_e          kind;
    logic [ADDR_W-1:0]   guess;

    // Interpret the incoming class code.
    always_comb kind = insn_kind_e'(f_kind);

    npc_predict #(.ADDR_W(ADDR_W)) u_predict (
        .kind      (kind),
        .incr_pc   (f_incr_pc),
        .const_tgt (f_const_tgt),
        .guess     (guess)
    );

    npc_hold_reg #(.ADDR_W(ADDR_W)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (fetch_stall),
        .d     (guess),
        .q     (pred_pc)
    );

    npc_select #(.ADDR_W(ADDR_W)) u_select (
        .m_is_cjump   (m_is_cjump),
        .m_cond_true  (m_cond_true),
        .m_fallthru   (m_fallthru),
        .w_is_ret     (w_is_ret),
        .w_ret_addr   (w_ret_addr),
        .stored_guess (pred_pc),
        .fetch_pc     (fetch_pc),
        .mispredict   (mispredict)
    );

    // R1
    seq_guess_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_stall && f_kind == 2'd0) |=> pred_pc == $past(f_incr_pc));

    // R2
    jump_guess_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_stall && f_kind == 2'd1) |=> pred_pc == $past(f_const_tgt));

    // R3
    cjump_guess_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_stall && f_kind == 2'd2) |=> pred_pc == $past(f_const_tgt));

    // R5
    fix_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_is_cjump && !m_cond_true) |-> (mispredict && fetch_pc == m_fallthru));

    // R6
    ret_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mispredict && w_is_ret) |-> fetch_pc == w_ret_addr);

    // R8
    use_guess_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mispredict && !w_is_ret) |-> fetch_pc == pred_pc);

    // R9
    no_false_squash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!m_is_cjump || m_cond_true) |-> !mispredict);

endmodule

// File: tb/test_next_pc_unit.sv
`timescale 1ns/1ps
module test_next_pc_unit;

    localparam int W = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fetch_stall = 1'b0;
    logic [1:0]    f_kind = 2'd0;
    logic [W-1:0]  f_incr_pc = '0;
    logic [W-1:0]  f_const_tgt = '0;
    logic          m_is_cjump = 1'b0;
    logic          m_cond_true = 1'b0;
    logic [W-1:0]  m_fallthru = '0;
    logic          w_is_ret = 1'b0;
    logic [W-1:0]  w_ret_addr = '0;
    logic [W-1:0]  fetch_pc;
    logic [W-1:0]  pred_pc;
    logic          mispredict;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    logic [W-1:0] exp_pred;

    next_pc_unit #(.ADDR_W(W)) i_next_pc_unit (
        .clk(clk), .rst_n(rst_n), .fetch_stall(fetch_stall),
        .f_kind(f_kind), .f_incr_pc(f_incr_pc), .f_const_tgt(f_const_tgt),
        .m_is_cjump(m_is_cjump), .m_cond_true(m_cond_true),
        .m_fallthru(m_fallthru), .w_is_ret(w_is_ret),
        .w_ret_addr(w_ret_addr), .fetch_pc(fetch_pc),
        .pred_pc(pred_pc), .mispredict(mispredict)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin
        // R10: reset state
        repeat (2) @(posedge clk);
        #1;
        chk("R10", pred_pc, '0);
        chk("R10", fetch_pc, '0);
        chk("R9", {31'd0, mispredict}, '0);
        @(negedge clk);
        rst_n = 1'b1;
        exp_pred = '0;

        for (int i = 0; i < 64; i++) begin
            logic mis;
            string rq;
            @(negedge clk);
            f_kind      = i[1:0];
            m_is_cjump  = i[2];
            m_cond_true = i[3];
            w_is_ret    = i[4];
            fetch_stall = i[5];
            f_incr_pc   = 32'h0000_1000 + i * 4;
            f_const_tgt = 32'h0000_8000 + i * 16;
            m_fallthru  = 32'h0000_4000 + i * 8;
            w_ret_addr  = 32'h0000_C000 + i * 12;
            #1;
            mis = i[2] && !i[3];
            if (mis) begin
                rq = i[4] ? "R7" : "R5";
                chk(rq, fetch_pc, m_fallthru);
                chk("R5", {31'd0, mispredict}, 32'd1);
            end else begin
                rq = i[4] ? "R6" : "R8";
                chk(rq, fetch_pc, i[4] ? w_ret_addr : exp_pred);
                chk("R9", {31'd0, mispredict}, 32'd0);
            end
            @(posedge clk);
            #1;
            if (i[5]) begin
                chk("R11", pred_pc, exp_pred);
            end else begin
                case (i[1:0])
                    2'd0: begin exp_pred = 32'h0000_1000 + i * 4;  rq = "R1"; end
                    2'd1: begin exp_pred = 32'h0000_8000 + i * 16; rq = "R2"; end
                    2'd2: begin exp_pred = 32'h0000_8000 + i * 16; rq = "R3"; end
                    default: begin exp_pred = 32'h0000_1000 + i * 4; rq = "R4"; end
                endcase
                chk(rq, pred_pc, exp_pred);
            end
        end

        // R10: reset overrides stall
        @(negedge clk);
        fetch_stall = 1'b1;
        m_is_cjump = 1'b0;
        w_is_ret = 1'b0;
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        chk("R10", pred_pc, '0);
        chk("R10", fetch_pc, '0);

        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule